// File: doc/BRIEF.md
# I2S Bit-Clock and Frame-Clock Generator with Selectable Divider Encoding

This block turns a fast reference clock into the serial bit clock and the left/right frame clock of an I2S transmitter, and shifts a stereo pair of sample words out on a serial data line. The reference input `clk` runs at twice the master audio clock rate. A bit-clock ratio of r master clocks therefore gives a bit-clock period of 2r `clk` cycles, high for r and low for r.

The ratio comes from one of two field encodings, chosen when the block is built by the `STYLE` parameter. In the power-of-two style, a 3-bit code holds log2 of the ratio, and only codes 0 to 3 are legal. In the linear style, an 8-bit field holds the ratio minus one, and the 3-bit code must read zero. In the linear style, a 16-bit/8-channel mode flag raises the ratio by half its value, and the ratio before that scaling must be even.

A separate field sets the frame length minus one, in bit clocks. The nominal value is 63. Divider and frame-length changes are held back until the next frame boundary. An illegal setting raises `cfg_err` and parks all outputs low. A legal setting restarts the block at a fresh frame.

Top module: `i2s_dual_clkgen`

## Requirements
- R1: With STYLE power-of-two, `div_code` values 0, 1, 2 and 3 give bit-clock ratios 1, 2, 4 and 8.
- R2: With STYLE power-of-two, `div_code` values 4 to 7 raise `cfg_err`. `div_lin` and `wide_mode` have no effect on the outputs.
- R3: With STYLE linear, the ratio is `div_lin`+1. A nonzero `div_code` raises `cfg_err`.
- R4: With STYLE linear and `wide_mode`=1, an even `div_lin`+1 value gives a ratio of 1.5×(`div_lin`+1). An odd value raises `cfg_err`.
- R5: Once running, `bclk` is high for exactly r `clk` cycles and low for exactly r `clk` cycles.
- R6: A frame lasts `frm_len_m1`+1 bit clocks. `lrclk` is low (left) for the first (`frm_len_m1`+1)/2 bit clocks, rounded down, and high (right) for the rest.
- R7: `lrclk` and `sdata` change only together with a falling edge of `bclk`.
- R8: Each channel word is sent MSB first. The MSB appears in the bit clock that follows the `lrclk` transition of that channel. `left_word` is sent while `lrclk` is low and `right_word` while it is high.
- R9: A new divider or frame-length value takes effect only at the start of a frame. Every bit clock within one frame has the same length.
- R10: `cfg_err` rises one `clk` cycle after an illegal setting appears. While it is high, `bclk`, `lrclk` and `sdata` are low. When the setting becomes legal again, output resumes with a new frame.
- R11: While `rst_n` is low, `bclk`, `lrclk`, `sdata` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the master audio clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| div_code | input | 3 | Power-of-two divider code (log2 of ratio) |
| div_lin | input | LIN_W | Linear divider field, ratio minus one |
| frm_len_m1 | input | FRM_W | Frame length in bit clocks, minus one |
| wide_mode | input | 1 | 16-bit/8-channel mode flag (ratio scaling in linear style) |
| left_word | input | SMP_W | Left-channel sample |
| right_word | input | SMP_W | Right-channel sample |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Frame clock, low for left |
| sdata | output | 1 | Serial data, MSB first |
| cfg_err | output | 1 | Illegal divider setting present |

## Verification
The bench drives one instance of each divider style and decodes both with an independent I2S receiver model. The hard cases are as follows. Ratio 1 in the power-of-two style is the shortest period; a design that mishandles it would produce no high phase at all. A mid-frame divider change must not apply at once; a design that applies it immediately would mix two bit-clock lengths inside one frame. The scaled 16-bit/8-channel ratio must be exact; a design that drops the scaling would run too fast, and one that misses the odd-ratio check would not flag the bad setting. Error entry and exit must leave the clocks parked low and then restart on a clean frame; a design that gets this wrong would show stray edges or misframed words afterwards.

// File: rtl/i2s_dual_pkg.sv
`timescale 1ns/1ps
package i2s_dual_pkg;
    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_style_e;

    localparam int CODE_W = 3;
endpackage

// File: rtl/i2s_ratio_decode.sv
`timescale 1ns/1ps
module i2s_ratio_decode #(
    parameter i2s_dual_pkg::div_style_e STYLE = i2s_dual_pkg::DIV_LINEAR,
    parameter int LIN_W = 8,
    parameter int RAT_W = LIN_W + 1
) (
    input  logic [i2s_dual_pkg::CODE_W-1:0] code_log,
    input  logic [LIN_W-1:0]                code_lin,
    input  logic                            wide_mode,
    output logic [RAT_W-1:0]                ratio,
    output logic                            bad
);
    generate
        if (STYLE == i2s_dual_pkg::DIV_POW2) begin : g_pow2
            logic unused_lin;
            assign unused_lin = ^{code_lin, wide_mode};
            always_comb begin
                ratio = RAT_W'(1) << code_log[1:0];
                bad   = (code_log > 3'd3);
            end
        end else begin : g_linear
            logic [RAT_W-1:0] base;
            always_comb begin
                base  = RAT_W'(code_lin) + RAT_W'(1);
                ratio = wide_mode ? (base + (base >> 1)) : base;
                bad   = (code_log != '0) || (wide_mode && base[0]);
            end
        end
    endgenerate
endmodule

// File: rtl/i2s_bclk_gen.sv
`timescale 1ns/1ps
module i2s_bclk_gen #(
    parameter int RAT_W = 9,
    parameter int PH_W  = RAT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [RAT_W-1:0] ratio,
    output logic             bclk,
    output logic             fall
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            bclk;
    } bst_t;

    bst_t st_d, st_q;
    logic [PH_W-1:0] top_ph;
    logic            wrap;

    always_comb begin
        top_ph = {ratio, 1'b0} - PH_W'(1);
        wrap   = (st_q.ph == top_ph);
        st_d   = st_q;
        if (!go) begin
            st_d = '0;
        end else begin
            st_d.ph   = wrap ? '0 : st_q.ph + PH_W'(1);
            st_d.bclk = (st_d.ph >= {1'b0, ratio});
        end
        fall = go && wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk = st_q.bclk;

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st_q.ph <= top_ph));
    assert_fall_from_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> st_q.bclk);
endmodule

// File: rtl/i2s_frame_shift.sv
`timescale 1ns/1ps
module i2s_frame_shift #(
    parameter int SMP_W = 32,
    parameter int FRM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             fall,
    input  logic [FRM_W-1:0] frm_m1,
    input  logic [SMP_W-1:0] left,
    input  logic [SMP_W-1:0] right,
    output logic             lrclk,
    output logic             sdata,
    output logic             boundary
);
    typedef struct packed {
        logic [FRM_W-1:0] bitc;
        logic             lr;
        logic             sd;
        logic [SMP_W-1:0] sh;
    } fst_t;

    fst_t st_d, st_q;
    logic [FRM_W-1:0] nxt_bit;
    logic [FRM_W:0]   half, nxt_ext;
    logic             last;

    always_comb begin
        last     = (st_q.bitc == frm_m1);
        nxt_bit  = last ? '0 : st_q.bitc + FRM_W'(1);
        nxt_ext  = {1'b0, nxt_bit};
        half     = ({1'b0, frm_m1} + (FRM_W+1)'(1)) >> 1;
        boundary = go && fall && last;
        st_d     = st_q;
        if (!go) begin
            st_d = '0;
        end else if (fall) begin
            st_d.bitc = nxt_bit;
            st_d.lr   = (nxt_ext >= half);
            if (nxt_ext == (FRM_W+1)'(1)) begin
                st_d.sd = left[SMP_W-1];
                st_d.sh = {left[SMP_W-2:0], 1'b0};
            end else if (nxt_ext == half + (FRM_W+1)'(1)) begin
                st_d.sd = right[SMP_W-1];
                st_d.sh = {right[SMP_W-2:0], 1'b0};
            end else begin
                st_d.sd = st_q.sh[SMP_W-1];
                st_d.sh = {st_q.sh[SMP_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lrclk = st_q.lr;
    assign sdata = st_q.sd;

    assert_lr_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.lr) && $past(go)) |-> $past(fall));
    assert_sd_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.sd) && $past(go)) |-> $past(fall));
endmodule

// File: rtl/i2s_dual_clkgen.sv
`timescale 1ns/1ps
module i2s_dual_clkgen #(
    parameter i2s_dual_pkg::div_style_e STYLE = i2s_dual_pkg::DIV_LINEAR,
    parameter int SMP_W = 32,
    parameter int LIN_W = 8,
    parameter int FRM_W = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [i2s_dual_pkg::CODE_W-1:0] div_code,
    input  logic [LIN_W-1:0]                div_lin,
    input  logic [FRM_W-1:0]                frm_len_m1,
    input  logic                            wide_mode,
    input  logic [SMP_W-1:0]                left_word,
    input  logic [SMP_W-1:0]                right_word,
    output logic                            bclk,
    output logic                            lrclk,
    output logic                            sdata,
    output logic                            cfg_err
);
    localparam int RAT_W = LIN_W + 1;

    typedef struct packed {
        logic [RAT_W-1:0] rat;
        logic [FRM_W-1:0] frm;
        logic             run;
        logic             err;
    } cst_t;

    cst_t st_d, st_q;
    logic [RAT_W-1:0] dec_rat;
    logic             dec_bad, go, fall, boundary;

    i2s_ratio_decode #(.STYLE(STYLE), .LIN_W(LIN_W), .RAT_W(RAT_W)) u_dec (
        .code_log (div_code),
        .code_lin (div_lin),
        .wide_mode(wide_mode),
        .ratio    (dec_rat),
        .bad      (dec_bad)
    );

    assign go = st_q.run && !dec_bad;

    always_comb begin
        st_d = st_q;
        if (dec_bad) begin
            st_d.run = 1'b0;
            st_d.err = 1'b1;
        end else begin
            st_d.err = 1'b0;
            st_d.run = 1'b1;
            if (!st_q.run || boundary) begin
                st_d.rat = dec_rat;
                st_d.frm = frm_len_m1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    i2s_bclk_gen #(.RAT_W(RAT_W)) u_bclk (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go),
        .ratio(st_q.rat),
        .bclk (bclk),
        .fall (fall)
    );

    i2s_frame_shift #(.SMP_W(SMP_W), .FRM_W(FRM_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .fall    (fall),
        .frm_m1  (st_q.frm),
        .left    (left_word),
        .right   (right_word),
        .lrclk   (lrclk),
        .sdata   (sdata),
        .boundary(boundary)
    );

    assign cfg_err = st_q.err;

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!bclk && !lrclk && !sdata));
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && !$past(boundary)) |-> ($stable(st_q.rat) && $stable(st_q.frm)));

    generate
        if (STYLE == i2s_dual_pkg::DIV_POW2) begin : g_chk_pow2
            assert_pow2_ratio_R1: assert property (@(posedge clk) disable iff (!rst_n)
                !dec_bad |-> ($countones(dec_rat) == 1));
        end else begin : g_chk_lin
            assert_quirk_mult3_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wide_mode && !dec_bad) |-> ((dec_rat % 3) == 0));
        end
    endgenerate
endmodule

// File: tb/i2s_dual_clkgen_test.sv
`timescale 1ns/1ps
module i2s_rx_probe (
    input  logic        clk,
    input  logic        clr,
    input  logic        bclk,
    input  logic        lrclk,
    input  logic        sdata,
    output int          hi_len,
    output int          lo_len,
    output int          frame_bits,
    output int          frames,
    output int          mism,
    output int          edge_bad,
    output logic [31:0] word_l,
    output logic [31:0] word_r
);
    int hi_c = 0, lo_c = 0, cnt = 0, pos = 0, k = 0, ref_len = 0;
    logic ref_ok = 0, b_prev = 0, lr_prev = 0, sd_prev = 0, lr_last = 0, ch = 0;
    logic [31:0] sh = '0;

    initial begin
        hi_len = 0; lo_len = 0; frame_bits = 0; frames = 0;
        mism = 0; edge_bad = 0; word_l = '0; word_r = '0;
    end

    always @(negedge clk) begin
        if (clr) begin
            hi_c = 0; lo_c = 0; cnt = 0; pos = 0; k = 0;
            ref_ok = 0; mism = 0; edge_bad = 0; lr_last = 0;
        end else begin
            if (((lrclk != lr_prev) || (sdata != sd_prev)) && !(b_prev && !bclk))
                edge_bad++;
            if (bclk && !b_prev) begin
                if (lrclk != lr_last) begin
                    pos = 0;
                    if (!lrclk) begin
                        frame_bits = cnt; cnt = 1; frames++;
                        ref_len = lo_c; ref_ok = 1;
                    end else begin
                        cnt++;
                        if (ref_ok && lo_c != ref_len) mism++;
                    end
                end else begin
                    pos++; cnt++;
                    if (ref_ok && lo_c != ref_len) mism++;
                end
                lo_len = lo_c; hi_c = 1; lr_last = lrclk;
                sh = {sh[30:0], sdata};
                if (pos == 1) begin k = 1; ch = lrclk; end
                else if (k > 0) k++;
                if (k == 32) begin
                    if (!ch) word_l = sh; else word_r = sh;
                    k = 0;
                end
            end else if (!bclk && b_prev) begin
                hi_len = hi_c;
                if (ref_ok && hi_c != ref_len) mism++;
                lo_c = 1;
            end else if (bclk) hi_c++;
            else lo_c++;
        end
        b_prev = bclk; lr_prev = lrclk; sd_prev = sdata;
    end
endmodule

module i2s_dual_clkgen_test;
    logic clk = 0, rst_n = 0, clr = 0, done = 0;
    logic [2:0]  e_code = 0, l_code = 2;
    logic [7:0]  lin = 3;
    logic [6:0]  frm = 63;
    logic        wide = 0;
    logic [31:0] lw = 0, rw = 0;
    logic e_bclk, e_lr, e_sd, e_err, l_bclk, l_lr, l_sd, l_err;
    int checks = 0, errors = 0;
    int pe_hi, pe_lo, pe_fb, pe_fr, pe_mm, pe_eb, pl_hi, pl_lo, pl_fb, pl_fr, pl_mm, pl_eb;
    logic [31:0] pe_wl, pe_wr, pl_wl, pl_wr;

    always #2.5 clk = ~clk;

    i2s_dual_clkgen #(.STYLE(i2s_dual_pkg::DIV_LINEAR)) uut (
        .clk(clk), .rst_n(rst_n), .div_code(e_code), .div_lin(lin), .frm_len_m1(frm),
        .wide_mode(wide), .left_word(lw), .right_word(rw),
        .bclk(e_bclk), .lrclk(e_lr), .sdata(e_sd), .cfg_err(e_err));

    i2s_dual_clkgen #(.STYLE(i2s_dual_pkg::DIV_POW2)) uut_legacy (
        .clk(clk), .rst_n(rst_n), .div_code(l_code), .div_lin(lin), .frm_len_m1(frm),
        .wide_mode(wide), .left_word(lw), .right_word(rw),
        .bclk(l_bclk), .lrclk(l_lr), .sdata(l_sd), .cfg_err(l_err));

    i2s_rx_probe p_ext (.clk(clk), .clr(clr), .bclk(e_bclk), .lrclk(e_lr), .sdata(e_sd),
        .hi_len(pe_hi), .lo_len(pe_lo), .frame_bits(pe_fb), .frames(pe_fr),
        .mism(pe_mm), .edge_bad(pe_eb), .word_l(pe_wl), .word_r(pe_wr));

    i2s_rx_probe p_leg (.clk(clk), .clr(clr), .bclk(l_bclk), .lrclk(l_lr), .sdata(l_sd),
        .hi_len(pl_hi), .lo_len(pl_lo), .frame_bits(pl_fb), .frames(pl_fr),
        .mism(pl_mm), .edge_bad(pl_eb), .word_l(pl_wl), .word_r(pl_wr));

    function automatic int ratio_ext(input int l, input logic w);
        int b = l + 1;
        return w ? (b * 3) / 2 : b;
    endfunction

    function automatic int ratio_leg(input int c);
        return 1 << c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_ext(input int n);
        int f0 = pe_fr;
        while (pe_fr < f0 + n) @(posedge clk);
    endtask

    task automatic wait_leg(input int n);
        int f0 = pl_fr;
        while (pl_fr < f0 + n) @(posedge clk);
    endtask

    task automatic verify_ext(input string tag, input int r, input int f);
        wait_ext(3);
        #1;
        check({tag, " R5 ext high"}, pe_hi, r);
        check({tag, " R5 ext low"}, pe_lo, r);
        check({tag, " R6 ext frame bits"}, pe_fb, f);
        check({tag, " R8 ext left word"}, pe_wl, lw);
        check({tag, " R8 ext right word"}, pe_wr, rw);
        check({tag, " R9 ext in-frame mismatch"}, pe_mm, 0);
        check({tag, " R7 ext off-fall edges"}, pe_eb, 0);
    endtask

    task automatic verify_leg(input string tag, input int r, input int f);
        wait_leg(3);
        #1;
        check({tag, " R1 leg high"}, pl_hi, r);
        check({tag, " R1 leg low"}, pl_lo, r);
        check({tag, " R6 leg frame bits"}, pl_fb, f);
        check({tag, " R8 leg left word"}, pl_wl, lw);
        check({tag, " R8 leg right word"}, pl_wr, rw);
        check({tag, " R9 leg in-frame mismatch"}, pl_mm, 0);
        check({tag, " R7 leg off-fall edges"}, pl_eb, 0);
    endtask

    task automatic err_quiet(input string tag, input logic is_ext);
        int highs = 0;
        @(posedge clk); @(negedge clk);
        check({tag, " R10 cfg_err"}, is_ext ? e_err : l_err, 1);
        repeat (30) begin
            @(negedge clk);
            if (is_ext ? (e_bclk | e_lr | e_sd) : (l_bclk | l_lr | l_sd)) highs++;
        end
        check({tag, " R10 outputs parked low"}, highs, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int r_old;
        lw = $urandom(32'h1234);
        lw = $urandom; rw = $urandom;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R11 reset bclk", {e_bclk, l_bclk}, 0);
        check("R11 reset lrclk", {e_lr, l_lr}, 0);
        check("R11 reset sdata", {e_sd, l_sd}, 0);
        check("R11 reset cfg_err", {e_err, l_err}, 0);
        step(); rst_n = 1;

        verify_ext("nominal R3", 4, 64);
        verify_leg("nominal", ratio_leg(2), 64);

        l_code = 0; step();
        verify_leg("ratio one", 1, 64);

        for (int i = 0; i < 6; i++) begin
            int sel;
            step();
            wide = 1'($urandom_range(0, 1));
            lin = 8'($urandom_range(0, 9));
            if (wide) lin = lin | 8'd1;
            sel = $urandom_range(0, 2);
            frm = (sel == 0) ? 7'd63 : (sel == 1) ? 7'd71 : 7'd79;
            l_code = 3'($urandom_range(0, 3));
            lw = $urandom; rw = $urandom;
            verify_ext("random R3 R4", ratio_ext(lin, wide), frm + 1);
            verify_leg("random R2 ignores linear field", ratio_leg(l_code), frm + 1);
        end

        step(); wide = 1; lin = 3; frm = 63;
        verify_ext("quirk R4", 6, 64);

        wait_ext(1);
        r_old = 6;
        repeat (40) @(posedge clk);
        #1; wide = 0; lin = 7; frm = 79;
        repeat (100) @(posedge clk);
        #1;
        check("R9 old ratio kept mid-frame", pe_hi, r_old);
        verify_ext("R9 new ratio after boundary", 8, 80);

        step(); e_code = 1;
        err_quiet("R3 nonzero code in linear style", 1'b1);
        step(); clr = 1; step(); clr = 0; e_code = 0;
        verify_ext("R10 recovery", 8, 80);

        step(); wide = 1; lin = 4;
        err_quiet("R4 odd ratio in wide mode", 1'b1);
        step(); l_code = 5;
        err_quiet("R2 illegal power-of-two code", 1'b0);
        step(); clr = 1; step(); clr = 0;
        wide = 0; lin = 5; l_code = 3; frm = 63;
        verify_ext("R10 resume ext", 6, 64);
        verify_leg("R10 resume leg", 8, 64);
        @(negedge clk);
        check("R10 cfg_err cleared", {e_err, l_err}, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule